// File: doc/BRIEF.md
# Multi-Mode Bidirectional Shift Register

This block is a parameterised-width register that can keep its contents, take a new word in parallel, or move its contents by one bit position per rising clock edge, toward the least significant end (right) or toward the most significant end (left). Each shift follows one of four styles: logical (zero fill), arithmetic (sign kept on a right shift, zero fill on a left shift), rotate (the leaving bit re-enters at the opposite end) or serial (the fill bit is taken from a serial input pin).

A second output, `shift_out`, keeps the bit that left the register on the most recent shift. It keeps that value through hold and load cycles. The block is controlled by plain select pins and has no handshake, so the surrounding logic chooses the operation for every cycle. A synchronous active-high reset clears both the register and `shift_out`. Barrel shifts and variable shift amounts are not supported.

Top module: `shreg_multi`

## Requirements
- R1: While `rst` is 1 at a rising edge, `q` and `shift_out` both become 0 after that edge.
- R2: With `op_sel` = 2'b00 (hold), `q` and `shift_out` keep their values across the edge.
- R3: With `op_sel` = 2'b11 (load), `q` takes `par_in` and `shift_out` keeps its value.
- R4: With `op_sel` = 2'b01 (right) and `kind_sel` = 2'b00 (logical), `q` becomes the old `q` shifted toward bit 0 with 0 entering bit W-1, and `shift_out` takes the old bit 0 (for example, 1110 becomes 0111).
- R5: With `op_sel` = 2'b10 (left) and `kind_sel` = 2'b00, `q` becomes the old `q` shifted toward bit W-1 with 0 entering bit 0, and `shift_out` takes the old bit W-1 (for example, 1101 becomes 1010).
- R6: With `op_sel` = 2'b01 and `kind_sel` = 2'b01 (arithmetic), the old bit W-1 is copied into the new bit W-1 (for example, 1110 becomes 1111).
- R7: With `op_sel` = 2'b10 and `kind_sel` = 2'b01, the result equals the logical left shift of R5.
- R8: With `kind_sel` = 2'b10 (rotate), the bit that leaves one end enters the other end, in both directions (for example, 0101 rotated left becomes 1010).
- R9: With `kind_sel` = 2'b11 (serial), the value of `ser_in` fills the vacated end, which is bit W-1 on a right shift and bit 0 on a left shift.
- R10: `ser_in` has no effect on `q` or `shift_out` unless the block is shifting with `kind_sel` = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | 00 hold, 01 right, 10 left, 11 load |
| kind_sel | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 serial fill |
| par_in | input | W | Parallel load word |
| ser_in | input | 1 | Fill bit for serial shifts |
| q | output | W | Register contents |
| shift_out | output | 1 | Bit that left the register on the last shift |

## Verification
The bench targets the edge bits, where errors are most likely. An arithmetic right shift of a negative word must fill with 1: a design that fills with 0 turns -2 into a large positive value. An arithmetic left shift must not keep the sign bit, so 1101 must give 1010. A rotate that drops the wrapped bit would behave like a logical shift, and the alternating patterns used by the bench show this. `ser_in` is toggled during hold, load and non-serial shifts, and `shift_out` is checked after loads and holds, so a design that updates `shift_out` on every edge, or uses the serial bit in every mode, produces visibly wrong outputs.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_RIGHT = 2'b01,
    OP_LEFT  = 2'b10,
    OP_LOAD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    K_LOGIC  = 2'b00,
    K_ARITH  = 2'b01,
    K_ROT    = 2'b10,
    K_SERIAL = 2'b11
  } kind_e;
endpackage

// File: rtl/shreg_edge_fill.sv
// Works out the bit that enters each end of the register for every shift style.
module shreg_edge_fill
  import shreg_pkg::*;
(
  input  kind_e kind,
  input  logic  msb,
  input  logic  lsb,
  input  logic  ser_in,
  output logic  fill_hi,  // enters bit W-1 on a right shift
  output logic  fill_lo   // enters bit 0 on a left shift
);
  always_comb begin
    unique case (kind)
      K_LOGIC:  begin fill_hi = 1'b0;   fill_lo = 1'b0;   end
      K_ARITH:  begin fill_hi = msb;    fill_lo = 1'b0;   end
      K_ROT:    begin fill_hi = lsb;    fill_lo = msb;    end
      K_SERIAL: begin fill_hi = ser_in; fill_lo = ser_in; end
      default:  begin fill_hi = 1'b0;   fill_lo = 1'b0;   end
    endcase
  end
endmodule

// File: rtl/shreg_cell.sv
// Next-state selector for one register bit.
module shreg_cell
  import shreg_pkg::*;
(
  input  op_e  op,
  input  logic cur,
  input  logic from_hi,  // neighbour toward MSB (used on right shift)
  input  logic from_lo,  // neighbour toward LSB (used on left shift)
  input  logic par,
  output logic nxt
);
  always_comb begin
    unique case (op)
      OP_HOLD:  nxt = cur;
      OP_RIGHT: nxt = from_hi;
      OP_LEFT:  nxt = from_lo;
      OP_LOAD:  nxt = par;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/shreg_multi.sv
module shreg_multi
  import shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_sel,
  input  logic [1:0]   kind_sel,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] q,
  output logic         shift_out
);
  localparam int MSB = W - 1;

  op_e          op;
  kind_e        kind;
  logic         fill_hi, fill_lo;
  logic [W-1:0] q_nxt;
  logic         so_nxt;

  assign op   = op_e'(op_sel);
  assign kind = kind_e'(kind_sel);

  shreg_edge_fill u_fill (
    .kind    (kind),
    .msb     (q[MSB]),
    .lsb     (q[0]),
    .ser_in  (ser_in),
    .fill_hi (fill_hi),
    .fill_lo (fill_lo)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hi_src, lo_src;
    if (i == MSB) begin : g_top
      assign hi_src = fill_hi;
    end else begin : g_mid_hi
      assign hi_src = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign lo_src = fill_lo;
    end else begin : g_mid_lo
      assign lo_src = q[i-1];
    end
    shreg_cell u_cell (
      .op      (op),
      .cur     (q[i]),
      .from_hi (hi_src),
      .from_lo (lo_src),
      .par     (par_in[i]),
      .nxt     (q_nxt[i])
    );
  end

  always_comb begin
    unique case (op)
      OP_RIGHT: so_nxt = q[0];
      OP_LEFT:  so_nxt = q[MSB];
      default:  so_nxt = shift_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q         <= '0;
      shift_out <= 1'b0;
    end else begin
      q         <= q_nxt;
      shift_out <= so_nxt;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (q == '0) && !shift_out);
  // R2
  a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    op_sel == 2'b00 |=> (q == $past(q)) && (shift_out == $past(shift_out)));
  // R3
  a_r3_load_takes: assert property (@(posedge clk) disable iff (rst)
    op_sel == 2'b11 |=> (q == $past(par_in)) && (shift_out == $past(shift_out)));
  // R4
  a_r4_right_out: assert property (@(posedge clk) disable iff (rst)
    op_sel == 2'b01 |=> shift_out == $past(q[0]));
  // R5
  a_r5_left_out: assert property (@(posedge clk) disable iff (rst)
    op_sel == 2'b10 |=> shift_out == $past(q[MSB]));
  // R6
  a_r6_arith_sign: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01 && kind_sel == 2'b01) |=> q[MSB] == $past(q[MSB]));
  // R7
  a_r7_arith_left_zero: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10 && kind_sel == 2'b01) |=> !q[0]);
  // R8
  a_r8_rot_wrap: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10 && kind_sel == 2'b10) |=> q[0] == $past(q[MSB]));
  // R9
  a_r9_serial_fill: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01 && kind_sel == 2'b11) |=> q[MSB] == $past(ser_in));
endmodule

// File: tb/shreg_multi_tb.sv
`timescale 1ns/1ps
module shreg_multi_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   op_sel, kind_sel;
  logic [W-1:0] par_in;
  logic         ser_in;
  logic [W-1:0] q;
  logic         shift_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] m_q;
  logic         m_so;

  always #2.5 clk = ~clk;

  shreg_multi #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_sel(op_sel), .kind_sel(kind_sel),
    .par_in(par_in), .ser_in(ser_in), .q(q), .shift_out(shift_out)
  );

  task automatic check(input string tag, input logic [W-1:0] aq, eq,
                       input logic aso, eso);
    n_vec++;
    if (aq !== eq || aso !== eso) begin
      n_bad++;
      $display("FAIL %s: q=%b so=%b expected q=%b so=%b", tag, aq, aso, eq, eso);
    end
  endtask

  // Expected result from the requirement text.
  task automatic model(input logic [1:0] op, kind, input logic [W-1:0] d,
                       input logic s);
    logic [W-1:0] nq;
    logic         nso;
    nq = m_q; nso = m_so;
    case (op)
      2'b01: begin
        nso = m_q[0];
        nq  = m_q >> 1;
        case (kind)
          2'b01: nq[W-1] = m_q[W-1];
          2'b10: nq[W-1] = m_q[0];
          2'b11: nq[W-1] = s;
          default: nq[W-1] = 1'b0;
        endcase
      end
      2'b10: begin
        nso = m_q[W-1];
        nq  = m_q << 1;
        case (kind)
          2'b10: nq[0] = m_q[W-1];
          2'b11: nq[0] = s;
          default: nq[0] = 1'b0;
        endcase
      end
      2'b11: nq = d;
      default: ;
    endcase
    m_q = nq; m_so = nso;
  endtask

  task automatic step(input string tag, input logic [1:0] op, kind,
                      input logic [W-1:0] d, input logic s);
    @(negedge clk);
    op_sel = op; kind_sel = kind; par_in = d; ser_in = s;
    @(posedge clk);
    #1;
    model(op, kind, d, s);
    check(tag, q, m_q, shift_out, m_so);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; op_sel = 2'b11; par_in = '1;
    @(posedge clk); #1;
    m_q = '0; m_so = 1'b0;
    check("R1 reset", q, '0, shift_out, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_hold_load;
    step("R3 load", 2'b11, 2'b00, 8'hA5, 1'b1);
    step("R2 hold", 2'b00, 2'b11, 8'h00, 1'b1);
    step("R2 hold", 2'b00, 2'b10, 8'hFF, 1'b0);
    step("R4 right", 2'b01, 2'b00, 8'h00, 1'b0);  // shift_out gets 1
    step("R3 load keeps so", 2'b11, 2'b00, 8'h3C, 1'b0);
    step("R2 hold keeps so", 2'b00, 2'b00, 8'h00, 1'b0);
  endtask

  task automatic t_logical;
    step("R3 load", 2'b11, 2'b00, 8'b1111_1110, 1'b0);
    step("R4 logical right", 2'b01, 2'b00, 8'h00, 1'b1);
    check("R4 literal", q, 8'b0111_1111, shift_out, 1'b0);
    step("R3 load", 2'b11, 2'b00, 8'b1110_1101, 1'b0);
    step("R5 logical left", 2'b10, 2'b00, 8'h00, 1'b1);
    check("R5 literal", q, 8'b1101_1010, shift_out, 1'b1);
    for (int i = 0; i < 8; i++) step("R5 drain", 2'b10, 2'b00, 8'h00, 1'b1);
  endtask

  task automatic t_arith;
    step("R3 load", 2'b11, 2'b00, 8'b1111_1110, 1'b0);
    step("R6 arith right neg", 2'b01, 2'b01, 8'h00, 1'b0);
    check("R6 literal", q, 8'b1111_1111, shift_out, 1'b0);
    step("R3 load", 2'b11, 2'b00, 8'b0100_0100, 1'b0);
    step("R6 arith right pos", 2'b01, 2'b01, 8'h00, 1'b1);
    step("R3 load", 2'b11, 2'b00, 8'b1111_1101, 1'b0);
    step("R7 arith left", 2'b10, 2'b01, 8'h00, 1'b1);
    check("R7 literal", q, 8'b1111_1010, shift_out, 1'b1);
  endtask

  task automatic t_rotate;
    step("R3 load", 2'b11, 2'b00, 8'b0101_0101, 1'b0);
    step("R8 rot left", 2'b10, 2'b10, 8'h00, 1'b0);
    check("R8 literal", q, 8'b1010_1010, shift_out, 1'b0);
    step("R3 load", 2'b11, 2'b00, 8'b0000_0001, 1'b0);
    step("R8 rot right", 2'b01, 2'b10, 8'h00, 1'b0);
    check("R8 wrap", q, 8'b1000_0000, shift_out, 1'b1);
    for (int i = 0; i < W; i++) step("R8 full ring", 2'b10, 2'b10, 8'h00, 1'b0);
  endtask

  task automatic t_serial;
    step("R3 load", 2'b11, 2'b00, 8'h00, 1'b0);
    step("R9 serial right", 2'b01, 2'b11, 8'h00, 1'b1);
    step("R9 serial right", 2'b01, 2'b11, 8'h00, 1'b0);
    step("R9 serial right", 2'b01, 2'b11, 8'h00, 1'b1);
    check("R9 literal", q, 8'b1010_0000, shift_out, 1'b0);
    step("R9 serial left", 2'b10, 2'b11, 8'h00, 1'b1);
    step("R9 serial left", 2'b10, 2'b11, 8'h00, 1'b1);
  endtask

  task automatic t_ser_ignored;
    step("R3 load", 2'b11, 2'b00, 8'h81, 1'b1);
    step("R10 logical right ser=1", 2'b01, 2'b00, 8'h00, 1'b1);
    step("R10 logical left ser=1", 2'b10, 2'b00, 8'h00, 1'b1);
    step("R10 arith left ser=1", 2'b10, 2'b01, 8'h00, 1'b1);
    step("R10 rot right ser=0", 2'b01, 2'b10, 8'h00, 1'b0);
    step("R10 hold ser toggles", 2'b00, 2'b11, 8'h00, 1'b0);
    step("R10 hold ser toggles", 2'b00, 2'b11, 8'h00, 1'b1);
  endtask

  task automatic t_mid_reset;
    step("R3 load", 2'b11, 2'b00, 8'hFF, 1'b0);
    step("R5 left", 2'b10, 2'b00, 8'h00, 1'b0);
    t_reset();
  endtask

  initial begin
    rst = 1'b1; op_sel = 2'b00; kind_sel = 2'b00; par_in = '0; ser_in = 1'b0;
    m_q = '0; m_so = 1'b0;
    t_reset();
    t_hold_load();
    t_logical();
    t_arith();
    t_rotate();
    t_serial();
    t_ser_ignored();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule